// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block paces one analog-to-digital conversion in master clock cycles. A 3-bit mode code picks three lengths: the start delay, the sampling window and the total conversion time. A conversion sequence is launched in one of two ways: the enable input rises, or the channel-select write strobe pulses while the block is enabled.

After a launch the block runs an optional wait period, then the start delay, then sampling, then the rest of the conversion. It pulses a completion interrupt when the conversion ends. While enable stays high, conversions follow one another directly: each new one starts at the sampling window and has no further start delay.

The start delay is not fixed. It is stretched from its minimum up to the next boundary of a free-running clock divider, so sampling always begins in a fixed phase relation to that divider. The analog front end, the successive-approximation data path and the result storage are outside this block. The only outputs are timing signals.

Top module: `adc_seq_timer`

## Requirements
- R1: Phase lengths per mode code. The sampling phase and the following conversion phase last these many cycles together: 000 → 40 + 248, 001 → 32 + 208, 010 → 24 + 168, 100 → 20 + 124, 101 → 16 + 104, 110 → 12 + 84. In each case the two add up to the conversion time.
- R2: The start delay lasts at least its minimum: 32 for codes 000, 28 for 001, 24 for 010, 16 for 100, 14 for 101, 12 for 110. It is extended by an alignment of 0 to 3 cycles for codes 0xx and 0 to 1 cycle for codes 1xx, ending on a divider boundary.
- R3: A sequence starts on the edge after `conv_en` goes 0→1, or on the edge where `chan_wr` is high while `conv_en` is high. A `chan_wr` pulse while `conv_en` is low has no effect.
- R4: A nonzero `wait_len` inserts exactly that many wait cycles before the start delay. A `wait_len` of 0 goes straight to the start delay.
- R5: Codes 011 and 111 are prohibited. They raise `mode_err`, no sequence starts, and a running sequence returns to idle.
- R6: With `conv_en` low, the block is idle on the next edge from any phase, and no interrupt is raised.
- R7: `irq` is high for exactly one cycle. That cycle is the one right after the last conversion cycle.
- R8: While `conv_en` stays high, the cycle after a conversion ends is in the sampling phase, with no start delay.
- R9: A `chan_wr` pulse during a running sequence restarts it at the wait or delay phase. If the pulse falls on the last conversion cycle, the restart happens and `irq` still pulses.
- R10: `phase` encodes 0 idle, 1 wait, 2 delay, 3 sample, 4 convert. `sh_en` is high only in sample. `busy` is high in every phase except idle.
- R11: After reset, `phase` is 0, and `busy`, `sh_en` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_en | input | 1 | Conversion enable |
| chan_wr | input | 1 | Channel-select write strobe (one cycle) |
| mode | input | 3 | Timing mode code |
| wait_len | input | WAIT_W | Wait cycles before the start delay (0 = none) |
| busy | output | 1 | Sequence in progress |
| sh_en | output | 1 | Sample-hold enable |
| phase | output | 3 | Current phase code |
| irq | output | 1 | Conversion-complete pulse |
| mode_err | output | 1 | Prohibited mode code selected |

## Verification
A conversion ending and a channel-select rewrite can fall on the same edge. In that case the completion interrupt and the restart compete.

The bench counts convert-phase cycles until it reaches the final one. It pulses `chan_wr` in exactly that cycle. On the next cycle it expects both `irq` high and the phase back at the start delay. A second collision drops `conv_en` during sampling. There the bench expects idle on the next cycle and no interrupt at any point afterwards.

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_en,
  input  logic              chan_wr,
  input  logic [2:0]        mode,
  input  logic [WAIT_W-1:0] wait_len,
  output logic              busy,
  output logic              sh_en,
  output logic [2:0]        phase,
  output logic              irq,
  output logic              mode_err
);
  localparam int CW = 9;
  localparam logic [2:0] S_IDLE = 3'd0, S_WAIT = 3'd1, S_DLY = 3'd2,
                         S_SMP = 3'd3, S_CNV = 3'd4;

  logic [2:0]    st;
  logic [CW-1:0] cnt;
  logic [1:0]    fdiv;
  logic          en_q;
  logic [CW-1:0] t_conv, t_smp, t_dmin;

  always_comb begin
    case (mode)
      3'b000:  begin t_conv = 9'd288; t_smp = 9'd40; t_dmin = 9'd32; end
      3'b001:  begin t_conv = 9'd240; t_smp = 9'd32; t_dmin = 9'd28; end
      3'b010:  begin t_conv = 9'd192; t_smp = 9'd24; t_dmin = 9'd24; end
      3'b100:  begin t_conv = 9'd144; t_smp = 9'd20; t_dmin = 9'd16; end
      3'b101:  begin t_conv = 9'd120; t_smp = 9'd16; t_dmin = 9'd14; end
      3'b110:  begin t_conv = 9'd96;  t_smp = 9'd12; t_dmin = 9'd12; end
      default: begin t_conv = 9'd96;  t_smp = 9'd12; t_dmin = 9'd12; end
    endcase
  end

  assign mode_err = mode[1] & mode[0];

  wire start    = conv_en & (~en_q | chan_wr);
  wire bnd      = mode[2] ? fdiv[0] : (fdiv == 2'b11);
  wire last_cnv = (st == S_CNV) && (cnt == t_conv - t_smp - 9'd1);
  wire [CW-1:0] wait_ext = CW'(wait_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      fdiv <= '0;
      en_q <= 1'b0;
      irq  <= 1'b0;
    end else begin
      fdiv <= fdiv + 2'd1;
      en_q <= conv_en;
      irq  <= 1'b0;
      if (!conv_en || mode_err) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else if (start) begin
        st  <= (wait_len != '0) ? S_WAIT : S_DLY;
        cnt <= '0;
        irq <= last_cnv;
      end else begin
        case (st)
          S_WAIT: if (cnt == wait_ext - 9'd1) begin st <= S_DLY; cnt <= '0; end
                  else cnt <= cnt + 9'd1;
          S_DLY:  if (cnt >= t_dmin - 9'd1 && bnd) begin st <= S_SMP; cnt <= '0; end
                  else cnt <= cnt + 9'd1;
          S_SMP:  if (cnt == t_smp - 9'd1) begin st <= S_CNV; cnt <= '0; end
                  else cnt <= cnt + 9'd1;
          S_CNV:  if (last_cnv) begin st <= S_SMP; cnt <= '0; irq <= 1'b1; end
                  else cnt <= cnt + 9'd1;
          default: begin st <= S_IDLE; cnt <= '0; end
        endcase
      end
    end
  end

  assign phase = st;
  assign busy  = (st != S_IDLE);
  assign sh_en = (st == S_SMP);

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R7
  irq_after_cnv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(phase) == S_CNV);
  // R6
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |=> (phase == S_IDLE) && !irq);
  // R5
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> !busy);
  // R8
  smp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_en) |-> ($past(phase) == S_DLY || $past(phase) == S_CNV));
endmodule

// File: tb/adc_seq_timer_test.sv
module adc_seq_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_en = 1'b0;
  logic       chan_wr = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [3:0] wait_len = 4'd0;
  logic       busy, sh_en, irq, mode_err;
  logic [2:0] phase;

  int n_chk = 0;
  int n_fail = 0;
  int irq_hits = 0;

  always #2 clk = ~clk;

  adc_seq_timer #(.WAIT_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .chan_wr(chan_wr),
    .mode(mode), .wait_len(wait_len), .busy(busy), .sh_en(sh_en),
    .phase(phase), .irq(irq), .mode_err(mode_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_smp(input logic [2:0] m);
    case (m) 3'b000: return 40; 3'b001: return 32; 3'b010: return 24;
             3'b100: return 20; 3'b101: return 16; default: return 12; endcase
  endfunction
  function automatic int exp_conv(input logic [2:0] m);
    case (m) 3'b000: return 288; 3'b001: return 240; 3'b010: return 192;
             3'b100: return 144; 3'b101: return 120; default: return 96; endcase
  endfunction
  function automatic int exp_dmin(input logic [2:0] m);
    case (m) 3'b000: return 32; 3'b001: return 28; 3'b010: return 24;
             3'b100: return 16; 3'b101: return 14; default: return 12; endcase
  endfunction

  task automatic count_run(input logic [2:0] ph, output int n);
    n = 0;
    while (phase == ph) begin
      n++;
      if (irq) irq_hits++;
      @(negedge clk);
    end
  endtask

  task automatic idle_all();
    conv_en = 1'b0; chan_wr = 1'b0; wait_len = 4'd0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    check(phase == 3'd0, "R11 phase", phase, 0);
    check(!busy && !sh_en && !irq, "R11 outputs", {busy, sh_en, irq}, 0);
  endtask

  task automatic t_mode(input logic [2:0] m);
    int nd, ns, nc, span;
    mode = m; irq_hits = 0;
    @(negedge clk);
    conv_en = 1'b1;
    @(negedge clk);
    check(phase == 3'd2 && busy, "R3 start on enable", phase, 2);
    count_run(3'd2, nd);
    span = m[2] ? 1 : 3;
    check(nd >= exp_dmin(m) && nd <= exp_dmin(m) + span, "R2 delay", nd, exp_dmin(m));
    check(sh_en && phase == 3'd3, "R10 sample flag", sh_en, 1);
    count_run(3'd3, ns);
    check(ns == exp_smp(m), "R1 sample length", ns, exp_smp(m));
    count_run(3'd4, nc);
    check(ns + nc == exp_conv(m), "R1 conversion time", ns + nc, exp_conv(m));
    check(irq_hits == 0, "R7 no early irq", irq_hits, 0);
    check(irq == 1'b1, "R7 irq at end", irq, 1);
    check(phase == 3'd3, "R8 back-to-back sample", phase, 3);
    @(negedge clk);
    check(irq == 1'b0, "R7 irq single cycle", irq, 0);
    idle_all();
  endtask

  task automatic t_wait();
    int nw;
    mode = 3'b110; wait_len = 4'd5;
    conv_en = 1'b1;
    @(negedge clk);
    count_run(3'd1, nw);
    check(nw == 5, "R4 wait length", nw, 5);
    check(phase == 3'd2, "R4 delay after wait", phase, 2);
    idle_all();
  endtask

  task automatic t_bad_mode();
    int seen;
    seen = 0;
    mode = 3'b011;
    @(negedge clk);
    check(mode_err == 1'b1, "R5 error flag 011", mode_err, 1);
    conv_en = 1'b1;
    repeat (40) begin @(negedge clk); if (busy) seen++; end
    check(seen == 0, "R5 no start", seen, 0);
    idle_all();
    mode = 3'b110; conv_en = 1'b1;
    repeat (20) @(negedge clk);
    mode = 3'b111;
    @(negedge clk);
    check(mode_err && phase == 3'd0, "R5 running sequence dropped", phase, 0);
    mode = 3'b110;
    idle_all();
  endtask

  task automatic t_abort();
    int hits;
    hits = 0;
    mode = 3'b110; conv_en = 1'b1;
    @(negedge clk);
    while (phase != 3'd3) @(negedge clk);
    repeat (3) @(negedge clk);
    conv_en = 1'b0;
    @(negedge clk);
    check(phase == 3'd0 && !busy, "R6 abort to idle", phase, 0);
    repeat (120) begin @(negedge clk); if (irq) hits++; end
    check(hits == 0, "R6 no irq after abort", hits, 0);
    chan_wr = 1'b1;
    @(negedge clk);
    chan_wr = 1'b0;
    @(negedge clk);
    check(phase == 3'd0, "R3 write ignored while disabled", phase, 0);
  endtask

  task automatic t_restart();
    mode = 3'b110; conv_en = 1'b1;
    @(negedge clk);
    while (phase != 3'd4) @(negedge clk);
    repeat (10) @(negedge clk);
    chan_wr = 1'b1;
    @(negedge clk);
    chan_wr = 1'b0;
    check(phase == 3'd2 && !irq, "R9 restart mid-conversion", phase, 2);
    idle_all();
  endtask

  task automatic t_collide();
    mode = 3'b110; conv_en = 1'b1;
    @(negedge clk);
    while (phase != 3'd4) @(negedge clk);
    repeat (83) @(negedge clk);
    check(phase == 3'd4, "R9 last convert cycle", phase, 4);
    chan_wr = 1'b1;
    @(negedge clk);
    chan_wr = 1'b0;
    check(irq == 1'b1, "R9 irq on collision", irq, 1);
    check(phase == 3'd2, "R9 restart wins", phase, 2);
    idle_all();
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mode(3'b000);
    t_mode(3'b001);
    t_mode(3'b010);
    t_mode(3'b100);
    t_mode(3'b101);
    t_mode(3'b110);
    t_wait();
    t_bad_mode();
    t_abort();
    t_restart();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule